// File: doc/BRIEF.md
# Thread Interrupt Presentation Context

This block keeps the interrupt management state of a single hardware thread for a single privilege ring. A routing engine delivers priority notifications to it. Each notification marks one of eight priority levels as pending. The block derives the most favoured pending priority, where a lower number is more favoured, and compares it with the current processor priority that software programs. From that comparison it drives the thread's interrupt line and an exception flag.

Software reaches the context through a small register port. A two-bit page index on that port says at which privilege level the access is made. Software reads the pending state and writes the current processor priority. It takes an interrupt with one acknowledge read, which returns the exception flag and the pending priority. In the same cycle that read raises the processor priority to the acknowledged level and retires the pending bit. The contexts of the other rings are separate instances of this block, selected by the `CTX_RING` parameter.

Top module: `thread_irq_ctx`

## Requirements
- R1: After reset the pending buffer is 0x00, the current priority is 0x00, the exception flag is 0 and the interrupt line is low.
- R2: A cycle with `ntf_valid` high sets bit `ntf_prio` of the 8-bit pending buffer. The buffer is read at register select 1 as {8'h00, buffer}.
- R3: The pending priority, read at select 2 as {8'h00, value}, is the index of the lowest set bit of the pending buffer, or 0xFF when the buffer is empty.
- R4: The interrupt line and the exception flag are high in a cycle only if, one cycle earlier, the pending priority was numerically less than the current priority and no acknowledge took place. A current priority of 0xFF admits every level, and 0x00 admits none.
- R5: A read at select 3 is the acknowledge. When the buffer is not empty it returns {flag, 7'b0, pending priority}. In the same clock edge it sets the current priority to the pending priority, clears that bit of the buffer and drops the line and the flag.
- R6: An acknowledge with an empty buffer returns {8'h00, 8'hFF} and changes no state.
- R7: A write at select 0 loads the current priority. Reading select 0 returns {8'h00, current priority}. On the next cycle the line follows the new comparison, so a write can raise the line or lower it.
- R8: Page index values give privilege rings 0 (physical), 1 (hypervisor), 2 (operating system) and 3 (user). An access with a page index above `CTX_RING` reads as zero, ignores writes and has no acknowledge side effect. Pages at or below `CTX_RING` have full access.
- R9: When a notification and an acknowledge of the same level fall in one cycle, the notification wins and that bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ntf_valid | input | 1 | Priority notification strobe |
| ntf_prio | input | 3 | Priority level being notified |
| acc_valid | input | 1 | Register access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_page | input | 2 | Privilege page index of the access |
| acc_sel | input | 2 | Register select: 0 current priority, 1 pending buffer, 2 pending priority, 3 acknowledge |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 16 | Combinational read data for the current access |
| irq_o | output | 1 | Processor interrupt line (also the exception flag) |

## Verification
The bench exercises the comparison boundary, where a pending priority equal to the current priority must not raise the line. A design that uses less-or-equal there would fire early. It runs an acknowledge on an empty buffer, where a careless design would load 0xFF into the current priority and unmask everything. It also drives an acknowledge and a same-level notification together, where clearing after setting would lose an interrupt. Accesses from the user page check that a privilege decode off by one neither leaks the priority nor takes an acknowledge.

// File: rtl/thread_irq_ctx.sv
module thread_irq_ctx #(
  parameter int PRIO_LEVELS = 8,
  parameter int CTX_RING    = 2,
  localparam int PW = $clog2(PRIO_LEVELS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ntf_valid,
  input  logic [PW-1:0] ntf_prio,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic [1:0]    acc_page,
  input  logic [1:0]    acc_sel,
  input  logic [7:0]    acc_wdata,
  output logic [15:0]   acc_rdata,
  output logic          irq_o
);

  logic [PRIO_LEVELS-1:0] ipb_q, ipb_set, ipb_clr;
  logic [7:0] cppr_q, pipr_w;
  logic       eo_q, priv, rd, wr, ack_fire, favoured;

  always_comb begin
    pipr_w = 8'hFF;
    for (int i = PRIO_LEVELS - 1; i >= 0; i--)
      if (ipb_q[i]) pipr_w = 8'(i);
  end

  assign priv     = int'(acc_page) <= CTX_RING;
  assign rd       = acc_valid && !acc_write && priv;
  assign wr       = acc_valid && acc_write && priv;
  assign ack_fire = rd && acc_sel == 2'd3 && pipr_w != 8'hFF;
  assign favoured = pipr_w < cppr_q;

  assign ipb_clr = ack_fire ? (PRIO_LEVELS'(1) << pipr_w[PW-1:0]) : '0;
  assign ipb_set = ntf_valid ? (PRIO_LEVELS'(1) << ntf_prio) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ipb_q  <= '0;
      cppr_q <= 8'h00;
      eo_q   <= 1'b0;
    end else begin
      ipb_q <= (ipb_q & ~ipb_clr) | ipb_set;
      if (ack_fire)
        cppr_q <= pipr_w;
      else if (wr && acc_sel == 2'd0)
        cppr_q <= acc_wdata;
      eo_q <= ack_fire ? 1'b0 : favoured;
    end
  end

  always_comb begin
    acc_rdata = '0;
    if (rd)
      case (acc_sel)
        2'd0: acc_rdata = {8'h00, cppr_q};
        2'd1: acc_rdata = {8'h00, 8'(ipb_q)};
        2'd2: acc_rdata = {8'h00, pipr_w};
        default: acc_rdata = {eo_q, 7'b0, pipr_w};
      endcase
  end

  assign irq_o = eo_q;

endmodule

module thread_irq_ctx_chk #(
  parameter int PRIO_LEVELS = 8,
  parameter int PW = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   ntf_valid,
  input logic [PW-1:0]          ntf_prio,
  input logic                   acc_valid,
  input logic                   acc_write,
  input logic                   priv,
  input logic                   ack_fire,
  input logic [PRIO_LEVELS-1:0] ipb_q,
  input logic [7:0]             cppr_q,
  input logic [7:0]             pipr_w,
  input logic [15:0]            acc_rdata,
  input logic                   irq_o
);

  assert_ntf_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid |=> ipb_q[$past(ntf_prio)]);

  assert_line_raise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_fire && pipr_w < cppr_q) |=> irq_o);

  assert_line_hold_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(pipr_w < cppr_q) |=> !irq_o);

  assert_ack_cppr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> (cppr_q == $past(pipr_w)) && !irq_o);

  assert_unpriv_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !priv) |-> acc_rdata == 16'h0000);

  assert_unpriv_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && !priv) |=> $stable(cppr_q));

endmodule

bind thread_irq_ctx thread_irq_ctx_chk #(.PRIO_LEVELS(PRIO_LEVELS), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ntf_valid(ntf_valid), .ntf_prio(ntf_prio),
  .acc_valid(acc_valid), .acc_write(acc_write), .priv(priv), .ack_fire(ack_fire),
  .ipb_q(ipb_q), .cppr_q(cppr_q), .pipr_w(pipr_w), .acc_rdata(acc_rdata),
  .irq_o(irq_o)
);

// File: tb/sim_thread_irq_ctx.sv
module sim_thread_irq_ctx;
  logic clk = 0, rst_n = 0;
  logic ntf_valid = 0, acc_valid = 0, acc_write = 0;
  logic [2:0] ntf_prio = 0;
  logic [1:0] acc_page = 0, acc_sel = 0;
  logic [7:0] acc_wdata = 0;
  logic [15:0] acc_rdata;
  logic irq_o;

  int n_chk = 0, n_fail = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  thread_irq_ctx u0 (.*);

  always @(negedge clk)
    if (rst_n && acc_valid && !acc_write) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL %s: read 0x%04h, expected nothing queued", "scoreboard", acc_rdata);
      end else begin
        automatic logic [15:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (acc_rdata !== e) begin
          n_fail++;
          $display("FAIL %s: rdata 0x%04h expected 0x%04h", t, acc_rdata, e);
        end
      end
    end

  task automatic cyc();
    @(posedge clk); #1;
    ntf_valid = 0; acc_valid = 0; acc_write = 0;
  endtask

  task automatic notify(input logic [2:0] p);
    @(posedge clk); #1;
    acc_valid = 0; ntf_valid = 1; ntf_prio = p;
    cyc();
  endtask

  task automatic rd(input logic [1:0] pg, input logic [1:0] sel,
                    input logic [15:0] e, input string t,
                    input logic also_ntf = 0, input logic [2:0] np = 0);
    @(posedge clk); #1;
    acc_valid = 1; acc_write = 0; acc_page = pg; acc_sel = sel;
    ntf_valid = also_ntf; ntf_prio = np;
    exp_q.push_back(e); tag_q.push_back(t);
    cyc();
  endtask

  task automatic wr(input logic [1:0] pg, input logic [7:0] d);
    @(posedge clk); #1;
    acc_valid = 1; acc_write = 1; acc_page = pg; acc_sel = 0; acc_wdata = d;
    cyc();
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    n_chk++;
    if (irq_o !== e) begin
      n_fail++;
      $display("FAIL %s: irq %0b expected %0b", t, irq_o, e);
    end
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: run not finished, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk_irq(0, "R1 line");
    rd(2, 0, 16'h0000, "R1 cppr");
    rd(2, 1, 16'h0000, "R1 ipb");
    rd(2, 2, 16'h00FF, "R3 empty pipr");

    notify(5); cyc();
    rd(2, 1, 16'h0020, "R2 ipb bit5");
    chk_irq(0, "R4 cppr 0 masks");
    wr(2, 8'hFF); cyc();
    chk_irq(1, "R7 write raises");
    rd(2, 3, 16'h8005, "R5 ack returns");
    chk_irq(0, "R5 ack drops line");
    rd(2, 0, 16'h0005, "R5 cppr loaded");
    rd(2, 1, 16'h0000, "R5 bit cleared");

    notify(6); notify(2); notify(4); cyc();
    rd(2, 2, 16'h0002, "R3 most favoured");
    chk_irq(1, "R4 2<5");
    rd(2, 3, 16'h8002, "R5 ack 2");
    cyc();
    rd(2, 1, 16'h0050, "R5 ipb after ack");
    chk_irq(0, "R4 4 vs 2 stays low");

    wr(2, 8'h04); cyc();
    chk_irq(0, "R4 equal priority no line");
    wr(2, 8'h07); cyc();
    chk_irq(1, "R7 write raises 4<7");
    wr(2, 8'h03); cyc();
    chk_irq(0, "R7 write lowers");

    wr(3, 8'hFF); cyc();
    chk_irq(0, "R8 user write ignored line");
    rd(3, 0, 16'h0000, "R8 user read zero");
    rd(3, 3, 16'h0000, "R8 user ack zero");
    rd(2, 1, 16'h0050, "R8 user ack no effect");
    rd(0, 0, 16'h0003, "R8 phys page cppr");
    rd(1, 2, 16'h0004, "R8 hyp page pipr");

    wr(1, 8'hFF); cyc();
    rd(2, 3, 16'h8004, "R5 ack 4");
    cyc();
    rd(2, 3, 16'h0006, "R5 ack 6 no flag");
    rd(2, 3, 16'h00FF, "R6 empty ack");
    rd(2, 0, 16'h0006, "R6 cppr unchanged");

    wr(2, 8'hFF); notify(1); cyc();
    rd(2, 3, 16'h8001, "R9 ack with ntf", 1'b1, 3'd1);
    rd(2, 1, 16'h0002, "R9 notify wins");
    cyc();
    chk_irq(0, "R9 1 vs cppr 1 low");

    repeat (2) cyc();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule